// File: doc/BRIEF.md
# Exception Priority Masking Gate

This block decides whether a single pending exception may activate, given three software-controlled masking registers. A one-bit global mask shuts out every exception whose priority is programmable. A one-bit fault-level mask shuts out everything except the non-maskable interrupt. A priority threshold, active only while nonzero, shuts out every programmable exception at that level or at any less urgent level. The three masks stack: an exception activates only if none of them blocks it.

Software reaches the masks in two ways. A register port reads or writes one mask at a time. A set/clear command port forces the global or the fault-level mask on or off, as an interrupt enable/disable instruction would. Both ports act only in privileged mode. The activation decision is purely combinational from the stored masks and the pending exception's number, priority and fixed-priority flag. Choosing among several pending exceptions is done elsewhere.

Top module: `exc_mask_gate`

## Requirements
- R1: A synchronous active-high reset clears all three masks to zero.
- R2: A privileged register write (reg_wr_i=1) takes effect on the next clock edge: reg_sel_i=0 loads the global mask from reg_wdata_i bit 0, 1 loads the fault-level mask from bit 0, 2 loads the 3-bit threshold from all of reg_wdata_i, and 3 changes nothing.
- R3: A privileged read shows the mask chosen by reg_sel_i on reg_rdata_o in the same cycle (one-bit masks in bit 0, upper bits zero); select value 3 reads zero.
- R4: While priv_i is low, register writes and set/clear commands change no mask, and reg_rdata_o reads zero.
- R5: A privileged set/clear command (cps_valid_i=1) loads cps_set_i into the global mask when cps_fault_i=0 and into the fault-level mask when cps_fault_i=1; when a register write targets the same mask in the same cycle, the register write wins.
- R6: permit_o is low whenever exc_pend_i is low.
- R7: While the global mask is set, a pending exception with exc_fixed_i=0 is not permitted; fixed-priority exceptions are unaffected by it.
- R8: While the fault-level mask is set, every pending exception whose number is not 2 is refused.
- R9: While the threshold is nonzero, a pending exception with exc_fixed_i=0 and priority value greater than or equal to the threshold is not permitted; a zero threshold blocks nothing, and fixed-priority exceptions are unaffected.
- R10: A pending exception numbered 2 (the non-maskable interrupt) is always permitted, and any pending exception that no mask blocks is permitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_i | input | 1 | Current access is privileged |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Mask select: 0 global, 1 fault-level, 2 threshold, 3 none |
| reg_wdata_i | input | 3 | Register write data |
| reg_rdata_o | output | 3 | Register read data for the selected mask |
| cps_valid_i | input | 1 | Set/clear command strobe |
| cps_fault_i | input | 1 | Command target: 0 global mask, 1 fault-level mask |
| cps_set_i | input | 1 | Value the command loads |
| exc_pend_i | input | 1 | An exception is pending |
| exc_num_i | input | 9 | Pending exception number (2 is the non-maskable interrupt) |
| exc_fixed_i | input | 1 | Pending exception has fixed priority |
| exc_prio_i | input | 3 | Pending exception priority, larger is less urgent |
| permit_o | output | 1 | Pending exception may activate |

## Verification
The assertions take for granted that exc_fixed_i is high whenever exc_num_i is 2, since the non-maskable interrupt is a fixed-priority exception, and that inputs settle between clock edges. The stimulus respects this by forcing the fixed flag on whenever it draws exception number 2, and by driving every input on the falling edge. Random exception numbers are drawn mostly from a small range around 2 so that the non-maskable and fixed-priority cases arise often against every mask combination.

// File: rtl/exc_mask_pkg.sv
package exc_mask_pkg;

    localparam int PRIO_W = 3;
    localparam int EXC_W  = 9;
    localparam int SEL_W  = 2;
    localparam logic [EXC_W-1:0] NMI_NUM = EXC_W'(2);

    typedef enum logic [SEL_W-1:0] {
        SEL_GLOBAL = 2'd0,
        SEL_FAULT  = 2'd1,
        SEL_BASE   = 2'd2,
        SEL_NONE   = 2'd3
    } mask_sel_e;

    typedef struct packed {
        logic              gmask;
        logic              fmask;
        logic [PRIO_W-1:0] base;
    } mask_state_t;

    typedef struct packed {
        logic              pend;
        logic [EXC_W-1:0]  num;
        logic              fixed;
        logic [PRIO_W-1:0] prio;
    } exc_req_t;

    function automatic logic base_blocks(logic [PRIO_W-1:0] base,
                                         logic [PRIO_W-1:0] prio);
        return (base != '0) && (prio >= base);
    endfunction

endpackage

// File: rtl/exc_mask_regs.sv
module exc_mask_regs
    import exc_mask_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              priv_i,
    input  logic              reg_wr_i,
    input  mask_sel_e         reg_sel_i,
    input  logic [PRIO_W-1:0] reg_wdata_i,
    output logic [PRIO_W-1:0] reg_rdata_o,
    input  logic              cps_valid_i,
    input  logic              cps_fault_i,
    input  logic              cps_set_i,
    output mask_state_t       state_o
);

    mask_state_t state_q;
    mask_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (priv_i) begin
            if (cps_valid_i) begin
                if (cps_fault_i) state_d.fmask = cps_set_i;
                else             state_d.gmask = cps_set_i;
            end
            if (reg_wr_i) begin
                unique case (reg_sel_i)
                    SEL_GLOBAL: state_d.gmask = reg_wdata_i[0];
                    SEL_FAULT:  state_d.fmask = reg_wdata_i[0];
                    SEL_BASE:   state_d.base  = reg_wdata_i;
                    SEL_NONE:   ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    always_comb begin
        reg_rdata_o = '0;
        if (priv_i) begin
            unique case (reg_sel_i)
                SEL_GLOBAL: reg_rdata_o[0] = state_q.gmask;
                SEL_FAULT:  reg_rdata_o[0] = state_q.fmask;
                SEL_BASE:   reg_rdata_o    = state_q.base;
                SEL_NONE:   reg_rdata_o    = '0;
            endcase
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/exc_mask_compare.sv
module exc_mask_compare
    import exc_mask_pkg::*;
(
    input  mask_state_t state_i,
    input  exc_req_t    req_i,
    output logic        permit_o
);

    logic is_nmi;
    logic glob_block;
    logic fault_block;
    logic thr_block;

    always_comb begin
        is_nmi      = (req_i.num == NMI_NUM);
        glob_block  = state_i.gmask && !req_i.fixed;
        fault_block = state_i.fmask;
        thr_block   = !req_i.fixed && base_blocks(state_i.base, req_i.prio);
        permit_o    = req_i.pend &&
                      (is_nmi || !(glob_block || fault_block || thr_block));
    end

endmodule

// File: rtl/exc_mask_gate.sv
module exc_mask_gate
    import exc_mask_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              priv_i,
    input  logic              reg_wr_i,
    input  logic [SEL_W-1:0]  reg_sel_i,
    input  logic [PRIO_W-1:0] reg_wdata_i,
    output logic [PRIO_W-1:0] reg_rdata_o,
    input  logic              cps_valid_i,
    input  logic              cps_fault_i,
    input  logic              cps_set_i,
    input  logic              exc_pend_i,
    input  logic [EXC_W-1:0]  exc_num_i,
    input  logic              exc_fixed_i,
    input  logic [PRIO_W-1:0] exc_prio_i,
    output logic              permit_o
);

    mask_state_t state_q;
    exc_req_t    req;

    assign req = '{pend: exc_pend_i, num: exc_num_i,
                   fixed: exc_fixed_i, prio: exc_prio_i};

    exc_mask_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .priv_i      (priv_i),
        .reg_wr_i    (reg_wr_i),
        .reg_sel_i   (mask_sel_e'(reg_sel_i)),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .cps_valid_i (cps_valid_i),
        .cps_fault_i (cps_fault_i),
        .cps_set_i   (cps_set_i),
        .state_o     (state_q)
    );

    exc_mask_compare u_cmp (
        .state_i  (state_q),
        .req_i    (req),
        .permit_o (permit_o)
    );

endmodule

// File: rtl/exc_mask_gate_chk.sv
module exc_mask_gate_chk
    import exc_mask_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              priv_i,
    input logic [PRIO_W-1:0] reg_rdata_o,
    input logic              exc_pend_i,
    input logic [EXC_W-1:0]  exc_num_i,
    input logic              exc_fixed_i,
    input logic [PRIO_W-1:0] exc_prio_i,
    input logic              permit_o,
    input mask_state_t       state_q
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_q == '0));

    p_unpriv_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !priv_i |=> $stable(state_q));

    p_unpriv_read_r4: assert property (@(posedge clk) disable iff (rst)
        !priv_i |-> (reg_rdata_o == '0));

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !exc_pend_i |-> !permit_o);

    p_global_block_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q.gmask && !exc_fixed_i) |-> !permit_o);

    p_fault_block_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q.fmask && exc_num_i != NMI_NUM) |-> !permit_o);

    p_thresh_block_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q.base != '0 && !exc_fixed_i && exc_prio_i >= state_q.base)
        |-> !permit_o);

    p_nmi_pass_r10: assert property (@(posedge clk) disable iff (rst)
        (exc_pend_i && exc_num_i == NMI_NUM) |-> permit_o);

endmodule

bind exc_mask_gate exc_mask_gate_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .priv_i      (priv_i),
    .reg_rdata_o (reg_rdata_o),
    .exc_pend_i  (exc_pend_i),
    .exc_num_i   (exc_num_i),
    .exc_fixed_i (exc_fixed_i),
    .exc_prio_i  (exc_prio_i),
    .permit_o    (permit_o),
    .state_q     (state_q)
);

// File: tb/exc_mask_gate_tb.sv
`timescale 1ns/1ps
module exc_mask_gate_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       priv_i;
    logic       reg_wr_i;
    logic [1:0] reg_sel_i;
    logic [2:0] reg_wdata_i;
    logic [2:0] reg_rdata_o;
    logic       cps_valid_i;
    logic       cps_fault_i;
    logic       cps_set_i;
    logic       exc_pend_i;
    logic [8:0] exc_num_i;
    logic       exc_fixed_i;
    logic [2:0] exc_prio_i;
    logic       permit_o;

    int checks   = 0;
    int failures = 0;

    // bench model of the masks
    logic       m_g;
    logic       m_f;
    logic [2:0] m_b;

    always #2.5 clk = ~clk;

    exc_mask_gate u_dut (
        .clk(clk), .rst(rst), .priv_i(priv_i), .reg_wr_i(reg_wr_i),
        .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .cps_valid_i(cps_valid_i),
        .cps_fault_i(cps_fault_i), .cps_set_i(cps_set_i),
        .exc_pend_i(exc_pend_i), .exc_num_i(exc_num_i),
        .exc_fixed_i(exc_fixed_i), .exc_prio_i(exc_prio_i),
        .permit_o(permit_o)
    );

    function automatic logic exp_permit();
        if (!exc_pend_i) return 1'b0;
        if (exc_num_i == 9'd2) return 1'b1;
        if (m_f) return 1'b0;
        if (exc_fixed_i) return 1'b1;
        if (m_g) return 1'b0;
        if (m_b != 3'd0 && exc_prio_i >= m_b) return 1'b0;
        return 1'b1;
    endfunction

    function automatic string permit_tag();
        if (!exc_pend_i) return "R6";
        if (exc_num_i == 9'd2) return "R10";
        if (m_f) return "R8";
        if (!exc_fixed_i && m_g) return "R7";
        if (!exc_fixed_i && m_b != 3'd0) return "R9";
        return "R10";
    endfunction

    function automatic logic [2:0] exp_rdata();
        if (!priv_i) return 3'd0;
        case (reg_sel_i)
            2'd0: return {2'b00, m_g};
            2'd1: return {2'b00, m_f};
            2'd2: return m_b;
            default: return 3'd0;
        endcase
    endfunction

    task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        reg_wr_i = 0; reg_sel_i = 0; reg_wdata_i = 0;
        cps_valid_i = 0; cps_fault_i = 0; cps_set_i = 0;
        exc_pend_i = 0; exc_num_i = 0; exc_fixed_i = 0; exc_prio_i = 0;
    endtask

    // apply current inputs across one rising edge, update model
    task automatic step();
        @(posedge clk);
        if (priv_i) begin
            if (cps_valid_i) begin
                if (cps_fault_i) m_f = cps_set_i; else m_g = cps_set_i;
            end
            if (reg_wr_i) begin
                case (reg_sel_i)
                    2'd0: m_g = reg_wdata_i[0];
                    2'd1: m_f = reg_wdata_i[0];
                    2'd2: m_b = reg_wdata_i;
                    default: ;
                endcase
            end
        end
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] sel, logic [2:0] d);
        idle(); priv_i = 1; reg_wr_i = 1; reg_sel_i = sel; reg_wdata_i = d;
        step(); idle();
    endtask

    task automatic probe(logic [8:0] num, logic fx, logic [2:0] pr, string tag);
        exc_pend_i = 1; exc_num_i = num; exc_fixed_i = fx; exc_prio_i = pr;
        #1 check(tag, 9'(permit_o), 9'(exp_permit()));
        exc_pend_i = 0;
    endtask

    task automatic rd(logic [1:0] sel, string tag);
        reg_wr_i = 0; reg_sel_i = sel;
        #1 check(tag, 9'(reg_rdata_o), 9'(exp_rdata()));
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle(); priv_i = 1; rst = 1;
        m_g = 0; m_f = 0; m_b = 0;
        // dirty the masks, then reset
        @(negedge clk); rst = 0;
        wr(2'd0, 3'd1); wr(2'd1, 3'd1); wr(2'd2, 3'd5);
        rst = 1; step(); rst = 0;
        m_g = 0; m_f = 0; m_b = 0;
        rd(2'd0, "R1 global"); rd(2'd1, "R1 fault"); rd(2'd2, "R1 base");

        // R2 writes and R3 readback
        wr(2'd2, 3'd4); rd(2'd2, "R2 base write");
        rd(2'd2, "R3 base read");
        wr(2'd3, 3'd7); rd(2'd3, "R3 select 3 reads zero");
        rd(2'd2, "R2 select 3 wrote nothing");

        // R9 threshold boundaries, base=4
        probe(9'd20, 0, 3'd4, "R9 prio equal blocked");
        probe(9'd20, 0, 3'd3, "R9 prio above threshold passes");
        probe(9'd20, 0, 3'd7, "R9 least urgent blocked");
        probe(9'd3,  1, 3'd7, "R9 fixed unaffected");
        wr(2'd2, 3'd0);
        probe(9'd20, 0, 3'd7, "R9 zero threshold blocks nothing");

        // R4 unprivileged
        idle(); priv_i = 0; reg_wr_i = 1; reg_sel_i = 2'd2; reg_wdata_i = 3'd6;
        cps_valid_i = 1; cps_fault_i = 1; cps_set_i = 1;
        #1 check("R4 unpriv read zero", 9'(reg_rdata_o), 9'd0);
        step(); idle(); priv_i = 1;
        rd(2'd2, "R4 unpriv write ignored");
        rd(2'd1, "R4 unpriv cps ignored");

        // R5 set/clear and conflict
        cps_valid_i = 1; cps_fault_i = 0; cps_set_i = 1; step(); idle();
        rd(2'd0, "R5 cps sets global");
        probe(9'd20, 0, 3'd0, "R7 global blocks programmable");
        probe(9'd3,  1, 3'd0, "R7 fixed passes global");
        cps_valid_i = 1; cps_fault_i = 1; cps_set_i = 1;
        reg_wr_i = 1; reg_sel_i = 2'd1; reg_wdata_i = 3'd0; step(); idle();
        rd(2'd1, "R5 register write wins");
        cps_valid_i = 1; cps_fault_i = 1; cps_set_i = 1; step(); idle();
        probe(9'd3, 1, 3'd0, "R8 fault mask blocks fixed");
        probe(9'd2, 1, 3'd0, "R10 NMI through all masks");
        probe(9'd1, 1, 3'd0, "R8 fault mask blocks number 1");
        exc_pend_i = 0; exc_num_i = 9'd2; exc_fixed_i = 1;
        #1 check("R6 no pending", 9'(permit_o), 9'd0);
        idle();

        // random phase
        for (int i = 0; i < 3000; i++) begin
            priv_i      = ($urandom % 4) != 0;
            reg_wr_i    = ($urandom % 3) == 0;
            reg_sel_i   = 2'($urandom);
            reg_wdata_i = 3'($urandom);
            cps_valid_i = ($urandom % 4) == 0;
            cps_fault_i = 1'($urandom);
            cps_set_i   = 1'($urandom);
            exc_pend_i  = ($urandom % 5) != 0;
            exc_num_i   = (($urandom % 4) != 0) ? 9'($urandom % 5) : 9'($urandom);
            exc_fixed_i = (exc_num_i == 9'd2) ? 1'b1 : 1'($urandom);
            exc_prio_i  = 3'($urandom);
            #1;
            check(permit_tag(), 9'(permit_o), 9'(exp_permit()));
            check(priv_i ? "R3" : "R4", 9'(reg_rdata_o), 9'(exp_rdata()));
            step();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule